// File: doc/BRIEF.md
# Host Command Register with Busy Handshake

This block is the single 16-bit read/write register through which a host processor hands work to a communications engine. One write carries a 4-bit operation code, a 4-bit channel index and a busy flag. The register answers that write with a one-cycle strobe. The strobe carries the operation code and a one-hot select for the addressed channel engine. The busy flag stays set until that engine returns a completion pulse. While the flag is set the register ignores every host write, so a second command can never overwrite one that is still running.

A separate bit requests a software reset of the engine. The block drops that bit and the busy flag on its own within two clocks, and gives the channel engines a one-cycle clear pulse. It then runs a fixed-length internal reset routine and raises a status output for as long as the routine lasts. The host does not have to wait for the routine: normal command writes are accepted as soon as the busy flag reads clear.

Field positions are given with bit 15 as the most significant bit of `wr_data`/`rd_data`. The reset bit is bit 15, the operation code is bits 11:8, the channel index is bits 7:4 and the busy flag is bit 0. Bits 14:12 and 3:1 are reserved. The strobe is a plain pulse with no back-pressure. Each engine must take it in the cycle it appears, and the busy handshake is the only flow control.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, `rd_data` reads 0x0000, `cmd_stb` is all zero, and `rst_busy` and `eng_clear` are low.
- R2: A write accepted while the busy flag (bit 0) reads 0 stores the operation code (bits 11:8), the channel index (bits 7:4), the reset bit (bit 15) and the busy flag. These values read back on `rd_data` from the next cycle.
- R3: An accepted write with bit 0 = 1 and bit 15 = 0 produces exactly one cycle, in the cycle after the write, in which `cmd_stb` has only bit [channel index] set and `cmd_op` equals the written operation code. At all other times `cmd_stb` is zero.
- R4: While the busy flag reads 1, host writes are ignored: `rd_data` is unchanged and no strobe is produced.
- R5: While the busy flag is set, a pulse on `done_in[i]` clears it only when i equals the stored channel index. The flag reads 0 in the cycle after that pulse, and pulses on other channels leave it set.
- R6: A `done_in` pulse while the busy flag is already 0 changes nothing on `rd_data`.
- R7: Reserved bits 14:12 and 3:1 always read 0, whatever value was written to them.
- R8: An accepted write with bit 0 = 0 and bit 15 = 0 updates the fields but produces no strobe.
- R9: An accepted write with bit 15 = 1 reads back with bit 15 set for one cycle, with `eng_clear` high in that cycle. In the following cycle the whole register, including bits 15 and 0, reads 0x0000.
- R10: After a software reset, `rst_busy` is high for exactly RST_CYCLES consecutive cycles (default 60), starting in the cycle in which the register first reads 0x0000 again.
- R11: Command writes made while `rst_busy` is high are accepted and strobed as in R3, and they do not shorten or stop the reset routine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write enable for one cycle |
| wr_data | input | 16 | Host write word |
| rd_data | output | 16 | Current register contents |
| cmd_stb | output | NCH | One-hot command strobe, one bit per channel engine |
| cmd_op | output | 4 | Operation code that goes with the strobe |
| eng_clear | output | 1 | One-cycle pulse that clears every channel engine's state |
| done_in | input | NCH | Completion pulses, one bit per channel engine |
| rst_busy | output | 1 | High while the internal reset routine runs |

## Verification
The bench sends a write while the busy flag is set. A design that failed to lock the register would let that write overwrite the pending command and emit a second strobe. It also sends completion pulses from a channel that was not addressed, and pulses that arrive while the flag is already clear. A wrong design would release the flag too early, or flip a flag that is already clear.

For the software reset, the bench checks the one-cycle readback with bit 15 set and the return to zero one cycle later. It counts the cycles in which the reset routine is busy, so a routine that is off by one in either direction is caught. It also issues a command while the routine runs, which catches a design that stalls host writes or restarts the routine. All ones written to the reserved bits must read back as zero, and a write with the busy flag clear must produce no strobe.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 4;
  localparam int CH_W   = 4;
  // field positions, bit 15 is the most significant bit
  localparam int RST_POS = 15;
  localparam int OP_LSB  = 8;
  localparam int CH_LSB  = 4;
  localparam int FLG_POS = 0;

  function automatic logic [WORD_W-1:0] live_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[RST_POS] = 1'b1;
    m[FLG_POS] = 1'b1;
    for (int i = 0; i < OP_W; i++) m[OP_LSB+i] = 1'b1;
    for (int i = 0; i < CH_W; i++) m[CH_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cmdreg_word.sv
module cmdreg_word
  import cmdreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              done_hit,
  output logic [WORD_W-1:0] word_q,
  output logic              stb_q
);
  localparam logic [WORD_W-1:0] KEEP = live_mask();

  logic rst_bit, busy_bit;
  assign rst_bit  = word_q[RST_POS];
  assign busy_bit = word_q[FLG_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (rst_bit) begin
        word_q <= '0;
      end else if (busy_bit) begin
        if (done_hit) word_q[FLG_POS] <= 1'b0;
      end else if (wr_en) begin
        word_q <= wr_data & KEEP;
        stb_q  <= wr_data[FLG_POS] & ~wr_data[RST_POS];
      end
    end
  end

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_bit && !rst_bit && !done_hit) |=> $stable(word_q));
  // R9
  reset_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit |=> (word_q == '0));
  // R6
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_bit && !wr_en) |=> !word_q[FLG_POS]);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((word_q & ~KEEP) == '0));
endmodule

// File: rtl/cmdreg_chan_dec.sv
module cmdreg_chan_dec
  import cmdreg_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [CH_W-1:0] chan,
  input  logic [NCH-1:0]  done_in,
  output logic [NCH-1:0]  stb,
  output logic            done_hit
);
  logic [NCH-1:0] hit_vec;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign stb[i]     = fire && (chan == CH_W'(i));
    assign hit_vec[i] = done_in[i] && (chan == CH_W'(i));
  end

  assign done_hit = |hit_vec;

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |=> !(|stb));
endmodule

// File: rtl/cmdreg_rst_seq.sv
module cmdreg_rst_seq #(
  parameter int RST_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CNT_W'(RST_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R10
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R10
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy) |=> !busy);
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmdreg_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int RST_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [NCH-1:0]    cmd_stb,
  output logic [OP_W-1:0]   cmd_op,
  output logic              eng_clear,
  input  logic [NCH-1:0]    done_in,
  output logic              rst_busy
);
  logic [WORD_W-1:0] word_q;
  logic              stb_q;
  logic              done_hit;

  cmdreg_word u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .done_hit (done_hit),
    .word_q   (word_q),
    .stb_q    (stb_q)
  );

  cmdreg_chan_dec #(.NCH(NCH)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (stb_q),
    .chan     (word_q[CH_LSB +: CH_W]),
    .done_in  (done_in),
    .stb      (cmd_stb),
    .done_hit (done_hit)
  );

  cmdreg_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (word_q[RST_POS]),
    .busy  (rst_busy)
  );

  assign rd_data   = word_q;
  assign cmd_op    = word_q[OP_LSB +: OP_W];
  assign eng_clear = word_q[RST_POS];

  // R5
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[FLG_POS] && !rd_data[RST_POS] && !(|done_in)) |=> rd_data[FLG_POS]);
endmodule

// File: tb/sim_cmd_mailbox.sv
`timescale 1ns/1ps
module sim_cmd_mailbox;
  localparam int NCH = 16;
  localparam int RSTC = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [NCH-1:0] cmd_stb;
  logic [3:0] cmd_op;
  logic eng_clear;
  logic [NCH-1:0] done_in = '0;
  logic rst_busy;

  int checks = 0;
  int fails = 0;
  int busy_cnt = 0;
  logic [19:0] exp_q[$];

  always #5 clk = ~clk;

  cmd_mailbox #(.NCH(NCH), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .eng_clear(eng_clear), .done_in(done_in), .rst_busy(rst_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // driver: write at a negedge, visible after the next rising edge
  task automatic host_write(input logic [15:0] d, input bit accepted);
    wr_en = 1'b1;
    wr_data = d;
    if (accepted && d[0] && !d[15])
      exp_q.push_back({d[11:8], 16'(1) << d[7:4]});
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse_done(input int ch);
    done_in = '0;
    done_in[ch] = 1'b1;
    @(negedge clk);
    done_in = '0;
  endtask

  // monitor: scoreboard of command strobes (R3)
  always @(negedge clk) begin
    if (rst_n && cmd_stb != '0) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected strobe actual=0x%0h expected=none", {cmd_op, cmd_stb});
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        if ({cmd_op, cmd_stb} !== e) begin
          fails++;
          $display("FAIL R3 strobe actual=0x%0h expected=0x%0h", {cmd_op, cmd_stb}, e);
        end
      end
    end
    if (rst_n && rst_busy) busy_cnt++;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd", rd_data, 0);
    check("R1 stb", cmd_stb, 0);
    check("R1 busy", {rst_busy, eng_clear}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: graceful-stop style opcode 5 on channel 4
    host_write(16'h0541, 1'b1);
    check("R2 readback", rd_data, 16'h0541);
    @(negedge clk);
    check("R3 strobe gone", cmd_stb, 0);

    // R4: write while busy ignored
    host_write(16'h0A11, 1'b0);
    check("R4 locked", rd_data, 16'h0541);
    @(negedge clk);

    // R5: wrong channel done ignored, right channel clears
    pulse_done(1);
    check("R5 wrong chan", rd_data, 16'h0541);
    pulse_done(4);
    check("R5 right chan", rd_data, 16'h0540);

    // R6: done while clear ignored
    pulse_done(4);
    check("R6 idle done", rd_data, 16'h0540);

    // R7: reserved bits read zero
    host_write(16'h7FFF, 1'b1);
    check("R7 reserved", rd_data, 16'h0FF1);
    pulse_done(15);
    check("R7 flag cleared", rd_data, 16'h0FF0);

    // R8: fields without flag, no strobe (scoreboard flags any strobe)
    host_write(16'h0230, 1'b1);
    check("R8 fields", rd_data, 16'h0230);
    @(negedge clk);

    // R9: software reset
    busy_cnt = 0;
    host_write(16'h8001, 1'b1);
    check("R9 transient", rd_data, 16'h8001);
    check("R9 clear pulse", eng_clear, 1);
    @(negedge clk);
    check("R9 self clear", rd_data, 16'h0000);
    check("R10 busy up", rst_busy, 1);

    // R11: command during reset routine
    host_write(16'h0111, 1'b1);
    check("R11 accepted", rd_data, 16'h0111);
    check("R11 busy kept", rst_busy, 1);
    pulse_done(1);
    check("R11 done", rd_data, 16'h0110);

    repeat (RSTC + 5) @(negedge clk);
    // R10 length of reset routine
    check("R10 busy count", busy_cnt, RSTC);
    check("R10 busy down", rst_busy, 0);
    check("R3 all strobes seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule